// File: doc/BRIEF.md
# Prescaled Ramp PWM Generator

This block makes one pulse-width-modulated output from a ramp counter. A divider turns the system clock into position steps. Its ratio is set linearly, from 1 to 65535, and a ratio of 0 gives 65536. Each step moves a frame position.

The position has two shapes:
- Sawtooth: it counts down from the frame size to 1 and starts again.
- Triangle: it counts down from the frame size to 1, then climbs back from 1 to the frame size.

The output is high while the active sample is at least the current position. A sample of 0 therefore keeps the output low, and a sample equal to the frame size keeps it high.

Software writes a sample and a frame size together with one strobe. Both go into a staging pair. They are taken up only when a new frame begins, so a write in the middle of a frame never bends the frame that is running. The ramp shape is also taken up at that point. A one-cycle pulse marks every frame start, so firmware can pace its writes to it.

Top module: `pwm_ramp_gen`

## Requirements
- R1: While reset is held and right after it, `pwm_out` and `frame_start` are 0.
- R2: While `en` is 1, the position advances once every P cycles, where P is `prescale`, or 65536 when `prescale` is 0. After `en` rises, the first frame starts on the P-th clock edge with `en` high.
- R3: With `mode_sel`=0 (sawtooth), the positions of a frame of size F are F, F-1, …, 1, one per step. The next frame then starts.
- R4: With `mode_sel`=1 (triangle), the positions are F down to 1, then 1 up to F, one per step, so the frame lasts 2F steps.
- R5: `pwm_out` is 1 exactly when the frame is running and the active sample is greater than or equal to the current position.
- R6: An active sample of 0 keeps `pwm_out` low for a whole frame. An active sample equal to the frame size keeps it high for a whole frame.
- R7: A `sample_wr` pulse captures `sample` and `frame_size` into staging. The running frame's output and length are unaffected. The staged pair, with the level of `mode_sel`, takes effect on the next frame start.
- R8: `frame_start` is high for exactly the one cycle in which a newly loaded frame shows its first position, and at no other time.
- R9: A staged frame size of 0 acts as 65536.
- R10: While `en` is 0, `pwm_out` and `frame_start` are 0 and the divider and frame are cleared. Raising `en` again begins a fresh frame after P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low clears divider and frame |
| mode_sel | input | 1 | Ramp shape: 0 sawtooth, 1 triangle (taken at frame start) |
| prescale | input | 16 | Clocks per position step; 0 means 65536 |
| frame_size | input | 16 | Frame size captured on `sample_wr`; 0 means 65536 |
| sample | input | 16 | Compare value captured on `sample_wr` |
| sample_wr | input | 1 | Write strobe for the staging pair |
| pwm_out | output | 1 | PWM output |
| frame_start | output | 1 | One-cycle pulse at each frame start |

## Verification
A wrong divider count shows up as a shifted `frame_start` within one step period. A position that moves off its ramp changes the duty inside the same frame, and a missed reversal in triangle mode stretches the frame past 2F steps. A staging fault shows as a new duty appearing before `frame_start` rather than with it. These faults therefore appear at the ports within one frame of where they occur. The bench compares both outputs with its own frame model on every cycle.

// File: rtl/pwm_ramp_pkg.sv
`timescale 1ns/1ps
package pwm_ramp_pkg;
  localparam int PWM_W = 16;

  typedef enum logic {
    RAMP_SAW = 1'b0,
    RAMP_TRI = 1'b1
  } ramp_mode_e;
endpackage

// File: rtl/pwm_tick_div.sv
`timescale 1ns/1ps
module pwm_tick_div #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  localparam int CW = DW + 1;

  // linear ratio, zero widened to 2**DW
  function automatic logic [CW-1:0] span(input logic [DW-1:0] d);
    span = (d == '0) ? (CW'(1) << DW) : CW'(d);
  endfunction

  logic [CW-1:0] cnt_q;
  logic          last_w;

  assign last_w = (cnt_q >= span(div_i) - CW'(1));
  assign tick_o = en_i & last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!en_i || last_w) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CW'(1);
  end

  // R2: a step always restarts the count
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
  // R10: disabled divider sits at zero
  a_r10_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_frame_seq.sv
`timescale 1ns/1ps
module pwm_frame_seq
  import pwm_ramp_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  ramp_mode_e    mode_i,
  input  logic [FW-1:0] frame_i,
  input  logic [FW-1:0] sample_i,
  input  logic          wr_i,
  output logic          run_o,
  output logic [FW:0]   pos_o,
  output logic [FW-1:0] smp_o,
  output logic          start_o
);
  localparam int PW = FW + 1;

  function automatic logic [PW-1:0] widen(input logic [FW-1:0] v);
    widen = (v == '0) ? (PW'(1) << FW) : PW'(v);
  endfunction

  logic [FW-1:0] stg_smp_q, stg_frm_q;
  logic [FW-1:0] act_smp_q;
  logic [PW-1:0] act_frm_q, pos_q;
  ramp_mode_e    act_mode_q;
  logic          dir_up_q, run_q, start_q;
  logic          frame_end_w, reload_w;

  assign frame_end_w = (act_mode_q == RAMP_SAW) ? (pos_q == PW'(1))
                                                 : (dir_up_q && (pos_q == act_frm_q));
  assign reload_w    = tick_i && (!run_q || frame_end_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_smp_q <= '0;
      stg_frm_q <= '0;
    end else if (wr_i) begin
      stg_smp_q <= sample_i;
      stg_frm_q <= frame_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_smp_q  <= '0;
      act_frm_q  <= '0;
      act_mode_q <= RAMP_SAW;
      pos_q      <= '0;
      dir_up_q   <= 1'b0;
      run_q      <= 1'b0;
      start_q    <= 1'b0;
    end else if (!en_i) begin
      pos_q    <= '0;
      dir_up_q <= 1'b0;
      run_q    <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= reload_w;
      if (reload_w) begin
        act_smp_q  <= stg_smp_q;
        act_frm_q  <= widen(stg_frm_q);
        act_mode_q <= mode_i;
        pos_q      <= widen(stg_frm_q);
        dir_up_q   <= 1'b0;
        run_q      <= 1'b1;
      end else if (tick_i) begin
        if (act_mode_q == RAMP_SAW)  pos_q <= pos_q - PW'(1);
        else if (!dir_up_q) begin
          if (pos_q == PW'(1)) dir_up_q <= 1'b1;
          else                 pos_q    <= pos_q - PW'(1);
        end else               pos_q    <= pos_q + PW'(1);
      end
    end
  end

  assign run_o   = run_q;
  assign pos_o   = pos_q;
  assign smp_o   = act_smp_q;
  assign start_o = start_q;

  // R8: a frame start shows the full frame size, heading down
  a_r8_start_top: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (pos_q == act_frm_q) && !dir_up_q);
  // R3: position stays inside 1..frame size
  a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pos_q != '0) && (pos_q <= act_frm_q));
  // R2: no step, no movement
  a_r2_step_only: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> $stable(pos_q));
  // R7: active sample only changes at a reload
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && run_q && !reload_w) |=> $stable(act_smp_q) && $stable(act_frm_q));
endmodule

// File: rtl/pwm_cmp_out.sv
`timescale 1ns/1ps
module pwm_cmp_out #(
  parameter int FW = 16
) (
  input  logic          run_i,
  input  logic [FW:0]   pos_i,
  input  logic [FW-1:0] smp_i,
  output logic          pwm_o
);
  function automatic logic at_or_above(input logic [FW-1:0] s, input logic [FW:0] p);
    at_or_above = ({1'b0, s} >= p);
  endfunction

  assign pwm_o = run_i & at_or_above(smp_i, pos_i);
endmodule

// File: rtl/pwm_ramp_gen.sv
`timescale 1ns/1ps
module pwm_ramp_gen
  import pwm_ramp_pkg::*;
#(
  parameter int W = PWM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mode_sel,
  input  logic [W-1:0] prescale,
  input  logic [W-1:0] frame_size,
  input  logic [W-1:0] sample,
  input  logic         sample_wr,
  output logic         pwm_out,
  output logic         frame_start
);
  logic         tick_w, run_w;
  logic [W:0]   pos_w;
  logic [W-1:0] smp_w;
  ramp_mode_e   mode_w;

  assign mode_w = ramp_mode_e'(mode_sel);

  pwm_tick_div #(.DW(W)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(en), .div_i(prescale), .tick_o(tick_w)
  );

  pwm_frame_seq #(.FW(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick_w), .mode_i(mode_w),
    .frame_i(frame_size), .sample_i(sample), .wr_i(sample_wr),
    .run_o(run_w), .pos_o(pos_w), .smp_o(smp_w), .start_o(frame_start)
  );

  pwm_cmp_out #(.FW(W)) u_cmp (
    .run_i(run_w), .pos_i(pos_w), .smp_i(smp_w), .pwm_o(pwm_out)
  );

  // R6: zero sample never drives high
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && smp_w == '0) |-> !pwm_out);
  // R6: sample at frame size is high at the frame's top position
  a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && {1'b0, smp_w} == pos_w) |-> pwm_out);
  // R10: disabled block is silent on the next cycle
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out && !frame_start);
endmodule

// File: tb/sim_pwm_ramp_gen.sv
`timescale 1ns/1ps
module sim_pwm_ramp_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        mode_sel = 1'b0;
  logic [15:0] prescale = '0;
  logic [15:0] frame_size = '0;
  logic [15:0] sample = '0;
  logic        sample_wr = 1'b0;
  logic        pwm_out, frame_start;

  int total = 0;
  int bad   = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pwm_ramp_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_sel(mode_sel), .prescale(prescale),
    .frame_size(frame_size), .sample(sample), .sample_wr(sample_wr),
    .pwm_out(pwm_out), .frame_start(frame_start)
  );

  task automatic chk(input string r, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  // ---------- independent frame model ----------
  int m_div, m_j, m_L, m_F, m_S, st_s, st_f, ns, nf, eff_p;
  bit m_run, m_tri, m_fs, m_tick;

  function automatic int pos_at(int j, int f, bit tri_m);
    if (!tri_m || j < f) return f - j;
    return j - f + 1;
  endfunction

  function automatic bit exp_pwm();
    if (!m_run) return 1'b0;
    return m_S >= pos_at(m_j, m_F, m_tri);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_run = 0; m_fs = 0; m_j = 0; st_s = 0; st_f = 0;
      m_F = 0; m_S = 0; m_L = 0; m_tri = 0;
    end else begin
      ns = st_s; nf = st_f;
      if (sample_wr) begin ns = sample; nf = frame_size; end
      if (!en) begin
        m_div = 0; m_run = 0; m_fs = 0; m_j = 0;
      end else begin
        eff_p  = (prescale == 0) ? 65536 : prescale;
        m_tick = (m_div == eff_p - 1);
        m_div  = m_tick ? 0 : m_div + 1;
        m_fs   = 0;
        if (m_tick) begin
          if (!m_run || m_j == m_L - 1) begin
            m_F = (st_f == 0) ? 65536 : st_f;
            m_S = st_s; m_tri = mode_sel;
            m_L = m_tri ? 2 * m_F : m_F;
            m_j = 0; m_run = 1; m_fs = 1;
          end else m_j++;
        end
      end
      st_s = ns; st_f = nf;
    end
  end

  // per-cycle comparison, away from the active edge
  bit cmp_on = 0;
  int hi_n = 0, lo_n = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk({cur_req, " pwm_out (R5)"}, pwm_out, exp_pwm());
      chk("R8 frame_start", frame_start, m_fs);
      if (pwm_out) hi_n++; else lo_n++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input bit m, input int p, input int f, input int s);
    mode_sel = m; prescale = 16'(p); frame_size = 16'(f); sample = 16'(s);
    sample_wr = 1'b1;
    step(1);
    sample_wr = 1'b0;
  endtask

  task automatic to_fs(output int n);
    n = 0;
    do begin step(1); n++; end while (!frame_start && n < 70000);
  endtask

  int n;

  initial begin
    void'($urandom(32'h1a2b));
    step(3);
    chk("R1 pwm_out in reset", pwm_out, 0);
    chk("R1 frame_start in reset", frame_start, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 pwm_out after reset", pwm_out, 0);
    chk("R1 frame_start after reset", frame_start, 0);
    cmp_on = 1;

    // R3 sawtooth
    cur_req = "R3";
    load(0, 3, 5, 2); en = 1; step(3 * 5 * 3 + 5);
    en = 0; step(2);
    chk("R10 pwm_out low when disabled", pwm_out, 0);
    chk("R10 frame_start low when disabled", frame_start, 0);

    // R4 triangle
    cur_req = "R4";
    load(1, 2, 4, 3); en = 1; step(2 * 8 * 3 + 3);
    en = 0; step(1);

    // R6 zero sample
    cur_req = "R6";
    load(0, 1, 6, 0); en = 1; to_fs(n); hi_n = 0; step(12);
    chk("R6 sample 0 never high", hi_n, 0);
    en = 0; step(1);
    // R6 full sample, triangle
    load(1, 2, 6, 6); en = 1; to_fs(n); lo_n = 0; step(2 * 12 * 2);
    chk("R6 sample = frame size never low", lo_n, 0);
    en = 0; step(1);

    // R7 mid-frame write
    cur_req = "R7";
    load(0, 2, 8, 3); en = 1; to_fs(n); step(4);
    sample = 16'd8; frame_size = 16'd4; sample_wr = 1; step(1); sample_wr = 0;
    chk("R7 old sample still active after write", pwm_out, 0);
    to_fs(n);
    chk("R7 old frame length kept", n, 2 * 8 - 5);
    chk("R7 new sample active at frame start", pwm_out, 1);
    to_fs(n);
    chk("R7 new frame length", n, 2 * 4);
    en = 0; step(1);

    // R2 linear division and frame gap
    cur_req = "R2";
    load(0, 7, 1, 1); en = 1; to_fs(n);
    chk("R2 first start after P cycles", n, 7);
    to_fs(n);
    chk("R2 gap of P cycles", n, 7);
    en = 0; step(1);
    load(0, 0, 1, 0); en = 1; to_fs(n);
    chk("R2 prescale 0 gives 65536", n, 65536);
    en = 0; step(1);

    // R9 frame size 0
    cur_req = "R9";
    load(0, 1, 0, 65535); en = 1; to_fs(n);
    chk("R9 top position 65536 above max sample", pwm_out, 0);
    step(1);
    chk("R9 next position 65535 reached", pwm_out, 1);
    en = 0; step(1);

    // R10 restart mid-frame
    cur_req = "R10";
    load(1, 3, 5, 2); en = 1; step(20); en = 0; step(1);
    chk("R10 cleared on disable", pwm_out, 0);
    en = 1; to_fs(n);
    chk("R10 fresh frame after P cycles", n, 3);
    en = 0; step(1);

    // random segments
    cur_req = "R5";
    for (int k = 0; k < 40; k++) begin
      int f = 1 + int'($urandom % 12);
      load(1'($urandom), 1 + int'($urandom % 4), f, int'($urandom % (f + 2)));
      en = 1;
      for (int c = 0; c < 120; c++) begin
        if (($urandom % 16) == 0) begin
          int f2 = 1 + int'($urandom % 12);
          frame_size = 16'(f2); sample = 16'($urandom % (f2 + 2));
          mode_sel = 1'($urandom); sample_wr = 1;
        end
        step(1);
        sample_wr = 0;
      end
      en = 0; step(1);
    end

    cmp_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule